// File: doc/BRIEF.md
# Convolution Buffer Address Controller

This block sequences one convolution pass of a systolic processing array that is fed from a single shared on-chip buffer over one combined data bus. The buffer holds filter words in a low address region and input words in the region just above it. After a one-cycle `go` pulse the controller works through a fixed series of phases. It first raises the filter-load strobe for one cycle while the bus is still idle. It then reads every filter word in turn. Next it preloads a short run of input words so that each array column holds initial data, and then it pulses the array start.

In the run phase the controller fetches one new input word at the start of each accumulation window, which is 16 cycles by default. It does this for a fixed number of kernel-shift positions, 84 by default. Meanwhile it accepts the array's result-ready indication and turns each one into an output-buffer write at a counting address. Fetching and writing overlap, so new data streams in while finished results drain out. After the last result is written, a finished flag rises and stays high until the next accepted `go`. The buffer memory and the multiply-accumulate arithmetic are outside this block.

Top module: `conv_buf_ctrl`

## Requirements
- R1: While reset is asserted, and in the cycles after its release until a `go` is accepted, `rd_en`, `filt_load`, `in_load`, `arr_start`, `wr_en` and `fin` are all 0.
- R2: The cycle after a `go` is accepted, `filt_load` is 1 and `rd_en` is 0. The filter strobe leads the first filter read by exactly one cycle.
- R3: On the next FILT_WORDS cycles (default 100), `rd_en` and `filt_load` are 1 and `rd_addr` counts 0, 1, ... FILT_WORDS-1, one address per cycle.
- R4: On the next PRELOAD cycles (default 8), `rd_en` and `in_load` are 1 and `rd_addr` counts from FILT_WORDS upward, one address per cycle. `filt_load` is 0 in these cycles.
- R5: The next cycle carries a single-cycle `arr_start` pulse, with `rd_en`, `filt_load` and `in_load` all 0.
- R6: From the cycle after `arr_start`, `rd_en` is 1 on the first cycle of every WIN_LEN-cycle window (default 16), for exactly SHIFTS windows (default 84). On fetch k (k counting from 0), `rd_addr` = FILT_WORDS + PRELOAD + k.
- R7: When `arr_done` is 1 at a clock edge during the run phase, `wr_en` is 1 in the following cycle. `wr_addr` then equals the number of results captured earlier in this pass, starting at 0.
- R8: Capturing the SHIFTS-th result ends the pass. `fin` rises one cycle after that last `wr_en` and stays 1, with no further writes, until the next accepted `go`. That `go` clears `fin` one cycle after it is sampled.
- R9: A `go` during a pass is ignored, and the read schedule stays unchanged. An `arr_done` outside the run phase produces no write.
- R10: `rd_en` is 0 in every cycle not named in R3, R4 or R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| go | input | 1 | One-cycle pulse that starts a pass when the controller is idle |
| rd_addr | output | AW (8) | Shared buffer read address |
| rd_en | output | 1 | Shared buffer read enable |
| filt_load | output | 1 | Array strobe: filter words on the bus |
| in_load | output | 1 | Array strobe: initial input words on the bus |
| arr_start | output | 1 | One-cycle array start pulse |
| arr_done | input | 1 | Array result is ready to be captured |
| wr_addr | output | OW (7) | Output buffer write address |
| wr_en | output | 1 | Output buffer write enable |
| fin | output | 1 | Pass complete; held until the next accepted go |

## Verification
All strobes and the read address are decoded directly from registered state. They therefore change one edge after the condition that causes them: the filter strobe appears 1 cycle after `go` is sampled, filter reads cover cycles 2 to 101, preload reads cover 102 to 109, start falls on cycle 110, and window fetches fall on cycle 111 + 16k. A write appears 1 cycle after `arr_done` is sampled, and `fin` appears 2 cycles after it. The bench counts edges from the sampled `go`, works out the expected value of every output for each cycle from these offsets, and compares on the falling edge before it drives the next inputs.

// File: rtl/conv_ctrl_pkg.sv
package conv_ctrl_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_FPRE = 3'd1,
    PH_FILT = 3'd2,
    PH_INLD = 3'd3,
    PH_STRT = 3'd4,
    PH_RUN  = 3'd5
  } phase_t;
endpackage

// File: rtl/ctrl_rst_sync.sv
module ctrl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/ctrl_seq_fsm.sv
module ctrl_seq_fsm
  import conv_ctrl_pkg::*;
#(
  parameter int FILT_WORDS = 100,
  parameter int PRELOAD    = 8,
  parameter int CW         = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          last_cap,
  output phase_t        phase,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] FILT_LAST = CW'(FILT_WORDS - 1);
  localparam logic [CW-1:0] PRE_LAST  = CW'(PRELOAD - 1);

  phase_t        phase_n;
  logic [CW-1:0] cnt_n;

  always_comb begin
    phase_n = phase;
    cnt_n   = cnt;
    unique case (phase)
      PH_IDLE: if (go) begin
        phase_n = PH_FPRE;
        cnt_n   = '0;
      end
      PH_FPRE: begin
        phase_n = PH_FILT;
        cnt_n   = '0;
      end
      PH_FILT: begin
        if (cnt == FILT_LAST) begin
          phase_n = PH_INLD;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + CW'(1);
        end
      end
      PH_INLD: begin
        if (cnt == PRE_LAST) begin
          phase_n = PH_STRT;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt + CW'(1);
        end
      end
      PH_STRT: phase_n = PH_RUN;
      PH_RUN:  if (last_cap) phase_n = PH_IDLE;
      default: begin
        phase_n = PH_IDLE;
        cnt_n   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_n;
      cnt   <= cnt_n;
    end
  end
endmodule

// File: rtl/ctrl_win_timer.sv
module ctrl_win_timer #(
  parameter int WIN_LEN = 16,
  parameter int SHIFTS  = 84,
  parameter int WW      = 4,
  parameter int FW      = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic          fetch_now,
  output logic [FW-1:0] fidx
);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_LEN - 1);
  localparam logic [FW-1:0] FMAX     = FW'(SHIFTS);

  logic [WW-1:0] win_q, win_n;
  logic [FW-1:0] fidx_n;
  logic          tick_en;

  always_comb begin
    win_n  = win_q;
    fidx_n = fidx;
    if (!run) begin
      win_n  = '0;
      fidx_n = '0;
    end else if (win_q == WIN_LAST) begin
      win_n = '0;
      if (fidx < FMAX) fidx_n = fidx + FW'(1);
    end else begin
      win_n = win_q + WW'(1);
    end
  end

  assign tick_en   = run || (win_q != '0) || (fidx != '0);
  assign fetch_now = run && (win_q == '0) && (fidx < FMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      fidx  <= '0;
    end else if (tick_en) begin
      win_q <= win_n;
      fidx  <= fidx_n;
    end
  end
endmodule

// File: rtl/ctrl_wr_tracker.sv
module ctrl_wr_tracker #(
  parameter int SHIFTS = 84,
  parameter int OW     = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          arr_done,
  input  logic          go_acc,
  output logic          last_cap,
  output logic          wr_en,
  output logic [OW-1:0] wr_addr,
  output logic          fin
);
  localparam logic [OW-1:0] LAST = OW'(SHIFTS - 1);

  logic          cap;
  logic [OW-1:0] wcnt_q, wcnt_n;
  logic          fin_n;

  assign cap      = run && arr_done;
  assign last_cap = cap && (wcnt_q == LAST);

  always_comb begin
    wcnt_n = wcnt_q;
    if (go_acc)   wcnt_n = '0;
    else if (cap) wcnt_n = wcnt_q + OW'(1);
  end

  always_comb begin
    fin_n = fin;
    if (go_acc)                        fin_n = 1'b0;
    else if (wr_en && wr_addr == LAST) fin_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q  <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      fin     <= 1'b0;
    end else begin
      wcnt_q <= wcnt_n;
      wr_en  <= cap;
      fin    <= fin_n;
      if (cap) wr_addr <= wcnt_q;
    end
  end
endmodule

// File: rtl/conv_buf_ctrl.sv
module conv_buf_ctrl
  import conv_ctrl_pkg::*;
#(
  parameter int FILT_WORDS = 100,
  parameter int IN_WORDS   = 100,
  parameter int PRELOAD    = 8,
  parameter int WIN_LEN    = 16,
  parameter int SHIFTS     = 84,
  parameter int AW         = $clog2(FILT_WORDS + IN_WORDS),
  parameter int OW         = $clog2(SHIFTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic [AW-1:0] rd_addr,
  output logic          rd_en,
  output logic          filt_load,
  output logic          in_load,
  output logic          arr_start,
  input  logic          arr_done,
  output logic [OW-1:0] wr_addr,
  output logic          wr_en,
  output logic          fin
);
  localparam int CMAX = (FILT_WORDS > PRELOAD) ? FILT_WORDS : PRELOAD;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int WW   = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam int FW   = $clog2(SHIFTS + 1);
  localparam logic [AW-1:0] IN_BASE  = AW'(FILT_WORDS);
  localparam logic [AW-1:0] RUN_BASE = AW'(FILT_WORDS + PRELOAD);

  logic          rst_s_n;
  phase_t        phase;
  logic [CW-1:0] cnt;
  logic          fetch_now;
  logic [FW-1:0] fidx;
  logic          last_cap;
  logic          run;
  logic          go_acc;

  ctrl_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  ctrl_seq_fsm #(
    .FILT_WORDS (FILT_WORDS),
    .PRELOAD    (PRELOAD),
    .CW         (CW)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .go       (go),
    .last_cap (last_cap),
    .phase    (phase),
    .cnt      (cnt)
  );

  assign run    = (phase == PH_RUN);
  assign go_acc = go && (phase == PH_IDLE);

  ctrl_win_timer #(
    .WIN_LEN (WIN_LEN),
    .SHIFTS  (SHIFTS),
    .WW      (WW),
    .FW      (FW)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .run       (run),
    .fetch_now (fetch_now),
    .fidx      (fidx)
  );

  ctrl_wr_tracker #(
    .SHIFTS (SHIFTS),
    .OW     (OW)
  ) u_wr (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .run      (run),
    .arr_done (arr_done),
    .go_acc   (go_acc),
    .last_cap (last_cap),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .fin      (fin)
  );

  always_comb begin
    unique case (phase)
      PH_FILT: rd_addr = AW'(cnt);
      PH_INLD: rd_addr = IN_BASE + AW'(cnt);
      default: rd_addr = RUN_BASE + AW'(fidx);
    endcase
  end

  assign rd_en     = (phase == PH_FILT) || (phase == PH_INLD) || fetch_now;
  assign filt_load = (phase == PH_FPRE) || (phase == PH_FILT);
  assign in_load   = (phase == PH_INLD);
  assign arr_start = (phase == PH_STRT);
endmodule

// File: rtl/conv_buf_ctrl_chk.sv
module conv_buf_ctrl_chk #(
  parameter int FILT_WORDS = 100,
  parameter int IN_WORDS   = 100,
  parameter int PRELOAD    = 8,
  parameter int AW         = 8,
  parameter int OW         = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] rd_addr,
  input logic          rd_en,
  input logic          filt_load,
  input logic          in_load,
  input logic          arr_start,
  input logic [OW-1:0] wr_addr,
  input logic          wr_en,
  input logic          fin
);
  localparam logic [AW-1:0] IN_BASE  = AW'(FILT_WORDS);
  localparam logic [AW-1:0] RUN_BASE = AW'(FILT_WORDS + PRELOAD);
  localparam logic [AW-1:0] TOP      = AW'(FILT_WORDS + IN_WORDS - 1);

  a_r1_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({filt_load, in_load, arr_start}));

  a_r2_strobe_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_load) |-> !rd_en);

  a_r3_filt_range: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_load && rd_en) |-> (rd_addr < IN_BASE));

  a_r3_filt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_load && rd_en && $past(filt_load && rd_en)) |-> (rd_addr == $past(rd_addr) + AW'(1)));

  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_load |-> (rd_en && rd_addr >= IN_BASE && rd_addr < RUN_BASE));

  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |=> !arr_start);

  a_r5_start_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start |-> !rd_en);

  a_r6_run_region: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !filt_load && !in_load) |-> (rd_addr >= RUN_BASE && rd_addr <= TOP));

  a_r8_fin_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fin) |-> $past(wr_en));

  a_r8_fin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (!wr_en && !rd_en));

  a_r7_wr_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (wr_en || $stable(wr_addr)));
endmodule

bind conv_buf_ctrl conv_buf_ctrl_chk #(
  .FILT_WORDS (FILT_WORDS),
  .IN_WORDS   (IN_WORDS),
  .PRELOAD    (PRELOAD),
  .AW         (AW),
  .OW         (OW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_addr   (rd_addr),
  .rd_en     (rd_en),
  .filt_load (filt_load),
  .in_load   (in_load),
  .arr_start (arr_start),
  .wr_addr   (wr_addr),
  .wr_en     (wr_en),
  .fin       (fin)
);

// File: tb/tb_conv_buf_ctrl.sv
module tb_conv_buf_ctrl;
  localparam int FW_N = 100;
  localparam int PRE  = 8;
  localparam int WIN  = 16;
  localparam int NSH  = 84;
  localparam int T_RUN = 1 + FW_N + PRE + 1 + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       go = 1'b0;
  logic       arr_done = 1'b0;
  logic [7:0] rd_addr;
  logic       rd_en, filt_load, in_load, arr_start, wr_en, fin;
  logic [6:0] wr_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  conv_buf_ctrl dut (
    .clk(clk), .rst_n(rst_n), .go(go),
    .rd_addr(rd_addr), .rd_en(rd_en), .filt_load(filt_load),
    .in_load(in_load), .arr_start(arr_start), .arr_done(arr_done),
    .wr_addr(wr_addr), .wr_en(wr_en), .fin(fin)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R1: all strobes idle during and after reset
  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "rd_en in reset", int'(rd_en), 0);
    chk("R1", "strobes in reset", int'({filt_load, in_load, arr_start}), 0);
    chk("R1", "wr_en/fin in reset", int'({wr_en, fin}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "rd_en after release", int'(rd_en), 0);
    chk("R1", "fin after release", int'(fin), 0);
    arr_done = 1'b1;
    @(negedge clk);
    arr_done = 1'b0;
    @(negedge clk);
    chk("R9", "wr_en from idle arr_done", int'(wr_en), 0);
  endtask

  // One full pass; captures offered at window position dph.
  task automatic t_pass(input int dph, input int busy_go_t, input int noise_t);
    int caps = 0;
    int tlast = 1 << 30;
    int pend = 0;
    int pend_addr = 0;
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (int t = 1; t <= T_RUN + NSH * WIN + 6; t++) begin
      int e_rd = 0, e_ad = -1, e_fl = 0, e_il = 0, e_st = 0;
      int u;
      string rq;
      if (t == 1) begin e_fl = 1; rq = "R2"; end
      else if (t <= 1 + FW_N) begin e_fl = 1; e_rd = 1; e_ad = t - 2; rq = "R3"; end
      else if (t <= 1 + FW_N + PRE) begin e_il = 1; e_rd = 1; e_ad = FW_N + t - 2 - FW_N; rq = "R4"; end
      else if (t == 2 + FW_N + PRE) begin e_st = 1; rq = "R5"; end
      else begin
        u = t - T_RUN;
        rq = "R6";
        if (t <= tlast && (u % WIN) == 0 && (u / WIN) < NSH) begin
          e_rd = 1; e_ad = FW_N + PRE + u / WIN;
        end
      end
      if (e_ad >= 0 && t > 1 + FW_N && t <= 1 + FW_N + PRE) e_ad = FW_N + (t - 2 - FW_N);
      chk(e_rd ? rq : "R10", "rd_en", int'(rd_en), e_rd);
      if (e_rd) chk(rq, "rd_addr", int'(rd_addr), e_ad);
      chk(rq, "filt_load", int'(filt_load), e_fl);
      chk(rq, "in_load", int'(in_load), e_il);
      chk("R5", "arr_start", int'(arr_start), e_st);
      chk("R7", "wr_en", int'(wr_en), pend);
      if (pend) chk("R7", "wr_addr", int'(wr_addr), pend_addr);
      chk("R8", "fin", int'(fin), (t >= tlast + 2) ? 1 : 0);
      // drive inputs for the next edge
      pend = 0;
      arr_done = 1'b0;
      go = (t == busy_go_t) ? 1'b1 : 1'b0;
      if (t == noise_t) arr_done = 1'b1;
      if (t >= T_RUN && ((t - T_RUN) % WIN) == dph && caps < NSH) begin
        arr_done = 1'b1;
        pend = 1;
        pend_addr = caps;
        caps++;
        if (caps == NSH) tlast = t;
      end
      @(negedge clk);
    end
    go = 1'b0;
    arr_done = 1'b0;
  endtask

  // R8: after finishing, results are not written and fin holds
  task automatic t_after_fin();
    arr_done = 1'b1;
    @(negedge clk);
    arr_done = 1'b0;
    chk("R8", "fin held", int'(fin), 1);
    @(negedge clk);
    chk("R8", "no write after fin", int'(wr_en), 0);
    chk("R8", "fin still held", int'(fin), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_pass(15, 600, 50);   // R9: busy go and early arr_done ignored
    t_after_fin();
    t_pass(3, 20, 109);    // restart clears fin (R8), second pattern
    t_after_fin();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule